// File: doc/BRIEF.md
# Register-Mapped SPI Word Master

This block is an SPI master driven through a small 32-bit register interface. Software stages a data word in a four-entry transmit FIFO and writes the command register with the launch bit set. The block then sends between 1 and 32 bits, most significant bit first, on the serial clock and data-out lines while it samples the data-in line. Each received word lands right-aligned in a four-entry receive FIFO. A sticky completion flag and a set of sticky FIFO error flags form the handshake with software. Software clears these flags by writing ones to them.

A programmable divider sets the length of each serial-clock half-period. The two mode bits give the clock idle level (CPOL) and the sampling edge (CPHA) in the usual four SPI modes. There are four chip-select lines. Each line can be inverted on its own. The selected line is driven either by the transfer engine or directly from a software level bit.

Register offsets: command at 0x000, divider at 0x004, completion status at 0x010, FIFO status at 0x014, transmit push port at 0x108, receive pop port at 0x188. Read data is registered and appears on the cycle after the read strobe.

Top module: `spi_word_master`

## Requirements
- R1: After reset, every `cs_n` line is high, `sclk` is low, completion status (0x010) reads 0, and FIFO status (0x014) reads 0x005 (bit 0 receive empty, bit 2 transmit empty).
- R2: A command write with bit 31 (launch) and bit 30 (master enable) both set, while the engine is idle, sends bits [len:0] of the transmit FIFO head MSB first, where len is command bits 4:0. Bit 31 always reads back as 0. A launch with bit 30 clear starts nothing, and a launch during a transfer is ignored.
- R3: Mode bit 29 is CPOL, and `sclk` rests at that level while idle. Mode bit 28 is CPHA: data is sampled on the leading edge when it is 0 and on the trailing edge when it is 1. A transfer makes exactly 2*(len+1) `sclk` edges, each half-period lasting DIV+1 clock cycles, where DIV is register 0x004.
- R4: The bits sampled from `miso` are assembled MSB first and pushed right-aligned into the receive FIFO. Software pops them through 0x188.
- R5: Bit 30 of 0x010 sets when a transfer completes and clears when software writes 1 to it.
- R6: With command bit 21 clear, the line chosen by command bits 27:26 is low from before the first `sclk` edge until after the last one. All other lines stay high.
- R7: With command bit 21 set, the chosen line follows bit 20: 0 drives it low and 1 drives it high.
- R8: Command bit 22+i inverts line i, so that line is low when inactive and high when active.
- R9: A push to a full transmit FIFO drops the word and sets bit 7 and bit 8 of 0x014. Bit 3 reports transmit full.
- R10: A launch with transmit enabled (bit 11) and the transmit FIFO empty shifts zeros and sets bit 6 and bit 8 of 0x014.
- R11: A completed receive into a full receive FIFO drops the word and sets bit 5 and bit 8. A pop from an empty receive FIFO returns 0 and sets bit 4 and bit 8. Bit 1 reports receive full.
- R12: Bits 4 to 8 of 0x014 are sticky, and each clears only when software writes 1 to that bit. Bits 0 to 3 always show the live FIFO state.
- R13: With transmit enable (bit 11) clear, the engine shifts zeros and leaves the transmit FIFO untouched. With receive enable (bit 12) clear, nothing is pushed to the receive FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW (10) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Chip-select lines, active low unless inverted |

## Verification
The assertions assume that the bus never issues a read and a write in the same cycle. They also assume that `miso` changes only between sampling edges, as it does when it is looped back from `mosi`. The bench ties `miso` to `mosi` and uses one task for each kind of bus access, so both assumptions hold by construction. It sweeps every mode against every length with the divider varied. A bench-side capture on the mode's sampling edge checks the bit order without relying on the design's internal state.

// File: rtl/spi_wm_pkg.sv
package spi_wm_pkg;
  localparam int REG_W = 32;
  localparam int LEN_W = 5;
  localparam int NCS   = 4;

  localparam logic [9:0] OFS_CMD   = 10'h000;
  localparam logic [9:0] OFS_DIV   = 10'h004;
  localparam logic [9:0] OFS_XFER  = 10'h010;
  localparam logic [9:0] OFS_FSTAT = 10'h014;
  localparam logic [9:0] OFS_TXP   = 10'h108;
  localparam logic [9:0] OFS_RXP   = 10'h188;

  localparam int B_GO     = 31;
  localparam int B_READY  = 30;
  localparam int B_RX_UNR = 4;
  localparam int B_RX_OVF = 5;
  localparam int B_TX_UNR = 6;
  localparam int B_TX_OVF = 7;
  localparam int B_ERR    = 8;

  typedef struct packed {
    logic             master;
    logic [1:0]       mode;    // [1] = CPOL, [0] = CPHA
    logic [1:0]       cs_idx;
    logic [NCS-1:0]   cs_pol;
    logic             sw_cs;
    logic             sw_lvl;
    logic             rx_en;
    logic             tx_en;
    logic [LEN_W-1:0] len;
  } cmd_t;

  function automatic cmd_t word_to_cmd(logic [REG_W-1:0] w);
    cmd_t c;
    c.master = w[30];
    c.mode   = w[29:28];
    c.cs_idx = w[27:26];
    c.cs_pol = w[25:22];
    c.sw_cs  = w[21];
    c.sw_lvl = w[20];
    c.rx_en  = w[12];
    c.tx_en  = w[11];
    c.len    = w[4:0];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] cmd_to_word(cmd_t c);
    return {1'b0, c.master, c.mode, c.cs_idx, c.cs_pol, c.sw_cs, c.sw_lvl,
            7'b0, c.rx_en, c.tx_en, 6'b0, c.len};
  endfunction
endpackage

// File: rtl/spi_wm_fifo.sv
module spi_wm_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  wire do_push = push && !full;
  wire do_pop  = pop && !empty;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  assign dout  = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/spi_wm_shifter.sv
module spi_wm_shifter #(
  parameter int DW    = 32,
  parameter int LW    = 5,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [LW-1:0]    len,
  input  logic [DW-1:0]    word,
  input  logic [DIV_W-1:0] div,
  input  logic             cpol_idle,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             busy,
  output logic             done,
  output logic [DW-1:0]    rx_word
);
  logic             busy_q, done_q, sclk_q, cpha_q;
  logic [DIV_W-1:0] half_cnt, div_q;
  logic [LW:0]      edge_cnt, last_q;
  logic [DW-1:0]    tx_sr, rx_sr;

  // Even edge index = leading edge; sampling edge is leading when CPHA=0.
  wire lead_edge   = ~edge_cnt[0];
  wire sample_edge = lead_edge ^ cpha_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      sclk_q   <= 1'b0;
      cpha_q   <= 1'b0;
      half_cnt <= '0;
      div_q    <= '0;
      edge_cnt <= '0;
      last_q   <= '0;
      tx_sr    <= '0;
      rx_sr    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        sclk_q <= cpol_idle;
        if (start) begin
          busy_q   <= 1'b1;
          cpha_q   <= mode[0];
          sclk_q   <= mode[1];
          tx_sr    <= word << (DW - 1 - int'(len));
          rx_sr    <= '0;
          edge_cnt <= '0;
          half_cnt <= div;
          div_q    <= div;
          last_q   <= {len, 1'b1};
        end
      end else if (half_cnt != '0) begin
        half_cnt <= half_cnt - 1'b1;
      end else begin
        half_cnt <= div_q;
        sclk_q   <= ~sclk_q;
        edge_cnt <= edge_cnt + 1'b1;
        if (sample_edge)
          rx_sr <= {rx_sr[DW-2:0], miso};
        else if (edge_cnt != '0)
          tx_sr <= tx_sr << 1;
        if (edge_cnt == last_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = tx_sr[DW-1];
  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_word = rx_sr;
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spi_wm_pkg::*;
#(
  parameter int AW    = 10,
  parameter int DEPTH = 4,
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NCS-1:0]    cs_n
);
  cmd_t             cmd_q, cmd_nx;
  logic [DIV_W-1:0] div_q;
  logic             ready_q, rx_en_run;
  logic             rx_unr, rx_ovf, tx_unr, tx_ovf, err_q;
  logic [REG_W-1:0] rdata_q;
  logic [NCS-1:0]   cs_n_q;

  logic             tx_empty, tx_full, rx_empty, rx_full;
  logic [REG_W-1:0] tx_dout, rx_dout, eng_rx;
  logic             eng_busy, eng_done;

  wire sel_cmd   = (bus_addr == AW'(OFS_CMD));
  wire sel_div   = (bus_addr == AW'(OFS_DIV));
  wire sel_xfer  = (bus_addr == AW'(OFS_XFER));
  wire sel_fstat = (bus_addr == AW'(OFS_FSTAT));
  wire sel_txp   = (bus_addr == AW'(OFS_TXP));
  wire sel_rxp   = (bus_addr == AW'(OFS_RXP));

  wire  wr_cmd = bus_wr && sel_cmd;
  cmd_t cmd_w;
  assign cmd_w  = word_to_cmd(bus_wdata);
  assign cmd_nx = wr_cmd ? cmd_w : cmd_q;

  wire go        = wr_cmd && bus_wdata[B_GO] && cmd_w.master && !eng_busy;
  wire tx_take   = go && cmd_w.tx_en && !tx_empty;
  wire tx_unr_st = go && cmd_w.tx_en && tx_empty;
  wire tx_push   = bus_wr && sel_txp && !tx_full;
  wire tx_ovf_st = bus_wr && sel_txp && tx_full;
  wire rx_rd     = bus_rd && sel_rxp;
  wire rx_pop    = rx_rd && !rx_empty;
  wire rx_unr_st = rx_rd && rx_empty;
  wire rx_push   = eng_done && rx_en_run && !rx_full;
  wire rx_ovf_st = eng_done && rx_en_run && rx_full;
  wire any_err   = tx_unr_st | tx_ovf_st | rx_unr_st | rx_ovf_st;
  wire run       = go || eng_busy;

  wire w1c_f = bus_wr && sel_fstat;

  spi_wm_fifo #(.W(REG_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(tx_push), .pop(tx_take), .din(bus_wdata),
    .dout(tx_dout), .empty(tx_empty), .full(tx_full));

  spi_wm_fifo #(.W(REG_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .pop(rx_pop), .din(eng_rx),
    .dout(rx_dout), .empty(rx_empty), .full(rx_full));

  spi_wm_shifter #(.DW(REG_W), .LW(LEN_W), .DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst(rst), .start(go), .mode(cmd_w.mode), .len(cmd_w.len),
    .word(tx_take ? tx_dout : '0), .div(div_q), .cpol_idle(cmd_q.mode[1]),
    .miso(miso), .sclk(sclk), .mosi(mosi), .busy(eng_busy), .done(eng_done),
    .rx_word(eng_rx));

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      div_q     <= '0;
      ready_q   <= 1'b0;
      rx_en_run <= 1'b0;
      rx_unr    <= 1'b0;
      rx_ovf    <= 1'b0;
      tx_unr    <= 1'b0;
      tx_ovf    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      cmd_q <= cmd_nx;
      if (bus_wr && sel_div) div_q <= bus_wdata[DIV_W-1:0];
      if (go) rx_en_run <= cmd_w.rx_en;
      ready_q <= eng_done | (ready_q & ~(bus_wr && sel_xfer && bus_wdata[B_READY]));
      rx_unr  <= rx_unr_st | (rx_unr & ~(w1c_f && bus_wdata[B_RX_UNR]));
      rx_ovf  <= rx_ovf_st | (rx_ovf & ~(w1c_f && bus_wdata[B_RX_OVF]));
      tx_unr  <= tx_unr_st | (tx_unr & ~(w1c_f && bus_wdata[B_TX_UNR]));
      tx_ovf  <= tx_ovf_st | (tx_ovf & ~(w1c_f && bus_wdata[B_TX_OVF]));
      err_q   <= any_err   | (err_q  & ~(w1c_f && bus_wdata[B_ERR]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      unique case (1'b1)
        sel_cmd:   rdata_q <= cmd_to_word(cmd_q);
        sel_div:   rdata_q <= REG_W'(div_q);
        sel_xfer:  rdata_q <= REG_W'(ready_q) << B_READY;
        sel_fstat: rdata_q <= {23'b0, err_q, tx_ovf, tx_unr, rx_ovf, rx_unr,
                               tx_full, tx_empty, rx_full, rx_empty};
        sel_rxp:   rdata_q <= rx_empty ? '0 : rx_dout;
        default:   rdata_q <= '0;
      endcase
    end
  end

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    wire act = (cmd_nx.cs_idx == 2'(g)) && (cmd_nx.sw_cs ? !cmd_nx.sw_lvl : run);
    always_ff @(posedge clk) begin
      if (rst) cs_n_q[g] <= 1'b1;
      else     cs_n_q[g] <= cmd_nx.cs_pol[g] ? act : ~act;
    end
  end

  assign bus_rdata = rdata_q;
  assign cs_n      = cs_n_q;
endmodule

// File: rtl/spi_word_master_checker.sv
module spi_word_master_checker
  import spi_wm_pkg::*;
#(
  parameter int AW = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [AW-1:0]    bus_addr,
  input logic [REG_W-1:0] bus_rdata,
  input logic             sclk,
  input logic [NCS-1:0]   cs_n,
  input logic             busy,
  input logic             done,
  input logic             ready,
  input logic             rx_empty,
  input logic             tx_full,
  input logic             rx_unr,
  input logic             tx_ovf,
  input logic             err,
  input logic             cpol,
  input logic             sw_cs,
  input logic [NCS-1:0]   cs_pol,
  input logic [1:0]       cs_idx
);
  AST_GO_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == AW'(OFS_CMD)) |=> !bus_rdata[B_GO]); // R2

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $stable(cpol)) |-> (sclk == cpol)); // R3

  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    done |=> ready); // R5

  AST_CS_HW_SELECT: assert property (@(posedge clk) disable iff (rst)
    (busy && !sw_cs && cs_pol == '0) |-> !cs_n[cs_idx]); // R6

  AST_TX_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(OFS_TXP) && tx_full) |=> (tx_ovf && err)); // R9

  AST_RX_UNDERRUN_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == AW'(OFS_RXP) && rx_empty) |=> (bus_rdata == '0 && rx_unr)); // R11
endmodule

bind spi_word_master spi_word_master_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .sclk(sclk), .cs_n(cs_n), .busy(eng_busy),
  .done(eng_done), .ready(ready_q), .rx_empty(rx_empty), .tx_full(tx_full),
  .rx_unr(rx_unr), .tx_ovf(tx_ovf), .err(err_q), .cpol(cmd_q.mode[1]),
  .sw_cs(cmd_q.sw_cs), .cs_pol(cmd_q.cs_pol), .cs_idx(cmd_q.cs_idx));

// File: tb/spi_word_master_bench.sv
`timescale 1ns/1ps
module spi_word_master_bench;
  import spi_wm_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk, mosi, miso;
  logic [3:0]  cs_n;

  always #5 clk = ~clk;
  assign miso = mosi;

  spi_word_master u_spi_word_master (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // Bench-side serial capture on the mode's sampling edge
  bit          cap_rise = 1;
  logic [31:0] cap = '0;
  logic [3:0]  cs_seen = '1;
  int          n_edges = 0;
  longint      t0 = 0, t1 = 0;

  always @(posedge sclk) if (cap_rise) begin cap = {cap[30:0], mosi}; cs_seen = cs_n; end
  always @(negedge sclk) if (!cap_rise) begin cap = {cap[30:0], mosi}; cs_seen = cs_n; end
  always @(sclk) begin
    if (n_edges == 0) t0 = $time;
    if (n_edges == 1) t1 = $time;
    n_edges++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  function automatic logic [31:0] mk_cmd(bit go, bit master, logic [1:0] mode,
      logic [1:0] idx, logic [3:0] pol, bit sw, bit lvl, bit rxen, bit txen, logic [4:0] len);
    return {go, master, mode, idx, pol, sw, lvl, 7'b0, rxen, txen, 6'b0, len};
  endfunction

  function automatic logic [31:0] lmask(logic [4:0] len);
    return 32'((64'h1 << (int'(len) + 1)) - 1);
  endfunction

  task automatic wait_ready();
    logic [31:0] d;
    for (int k = 0; k < 3000; k++) begin
      rd(OFS_XFER, d);
      if (d[30]) return;
    end
    chk("R5 ready never set", 32'h0, 32'h4000_0000);
  endtask

  logic idle_lvl;

  task automatic run_xfer(input logic [1:0] mode, input logic [1:0] idx, input logic [3:0] pol,
                          input bit rxen, input bit txen, input logic [4:0] len, input logic [7:0] div);
    wr(OFS_DIV, {24'b0, div});
    wr(OFS_CMD, mk_cmd(0, 1, mode, idx, pol, 0, 0, rxen, txen, len));
    repeat (3) @(negedge clk);
    idle_lvl = sclk;
    cap_rise = (mode[1] == mode[0]);
    cap = '0; n_edges = 0;
    wr(OFS_CMD, mk_cmd(1, 1, mode, idx, pol, 0, 0, rxen, txen, len));
    wait_ready();
    wr(OFS_XFER, 32'h4000_0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d, w;
    logic [31:0] ws [5];
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk("R1 cs_n", {28'b0, cs_n}, 32'hF);
    chk("R1 sclk", {31'b0, sclk}, 32'h0);
    rd(OFS_FSTAT, d); chk("R1 fifo status", d, 32'h5);
    rd(OFS_XFER, d);  chk("R1 ready", d, 32'h0);

    // R2 R3 R4 R6: sweep every mode and length with varied divider
    for (int m = 0; m < 4; m++) begin
      for (int len = 0; len < 32; len++) begin
        logic [1:0] idx = 2'(len % 4);
        w = {16'hA5C3, 16'h96E1} ^ (32'h1111_1111 * m) ^ (32'h0102_0408 << (len % 7));
        wr(OFS_TXP, w);
        run_xfer(2'(m), idx, 4'h0, 1, 1, 5'(len), 8'(m));
        chk($sformatf("R3 idle sclk mode%0d", m), {31'b0, idle_lvl}, {31'b0, m[1]});
        chk($sformatf("R3 edges m%0d l%0d", m, len), n_edges, 2 * (len + 1));
        chk($sformatf("R3 half period m%0d", m), 32'(t1 - t0), 32'((m + 1) * 10));
        chk($sformatf("R2 mosi bits m%0d l%0d", m, len), cap, w & lmask(5'(len)));
        chk($sformatf("R6 cs during xfer l%0d", len), {28'b0, cs_seen}, {28'b0, ~(4'b1 << idx)});
        rd(OFS_RXP, d);
        chk($sformatf("R4 rx word m%0d l%0d", m, len), d, w & lmask(5'(len)));
      end
    end
    rd(OFS_FSTAT, d); chk("R12 clean after sweep", d, 32'h5);

    // R2 launch bit reads back 0
    rd(OFS_CMD, d); chk("R2 go self-clear", d[31], 32'h0);

    // R5 ready W1C
    wr(OFS_TXP, 32'h1234_5678);
    run_xfer(2'd0, 2'd0, 4'h0, 1, 1, 5'd7, 8'd0);
    rd(OFS_XFER, d); chk("R5 ready cleared by W1C", d, 32'h0);
    rd(OFS_RXP, d);  chk("R4 rx byte", d, 32'h78);
    wr(OFS_TXP, 32'h0000_00C3);
    wr(OFS_CMD, mk_cmd(1, 1, 2'd0, 2'd0, 4'h0, 0, 0, 1, 1, 5'd7));
    wait_ready();
    rd(OFS_XFER, d); chk("R5 ready set", d, 32'h4000_0000);
    wr(OFS_XFER, 32'h4000_0000);
    rd(OFS_XFER, d); chk("R5 ready W1C", d, 32'h0);
    rd(OFS_RXP, d);  chk("R4 rx C3", d, 32'hC3);

    // R2 launch without master enable does nothing
    wr(OFS_TXP, 32'h0000_BEEF);
    wr(OFS_CMD, mk_cmd(1, 0, 2'd0, 2'd0, 4'h0, 0, 0, 1, 1, 5'd15));
    repeat (40) @(negedge clk);
    rd(OFS_XFER, d);  chk("R2 no master no ready", d, 32'h0);
    rd(OFS_FSTAT, d); chk("R2 no master tx kept", d, 32'h1);
    run_xfer(2'd0, 2'd0, 4'h0, 1, 1, 5'd15, 8'd0);
    rd(OFS_RXP, d);   chk("R2 drained word", d, 32'hBEEF);

    // R2 launch while busy ignored
    wr(OFS_TXP, 32'hCAFE_0001);
    wr(OFS_TXP, 32'hCAFE_0002);
    wr(OFS_DIV, 32'd20);
    wr(OFS_CMD, mk_cmd(1, 1, 2'd0, 2'd0, 4'h0, 0, 0, 1, 1, 5'd31));
    repeat (10) @(negedge clk);
    wr(OFS_CMD, mk_cmd(1, 1, 2'd0, 2'd0, 4'h0, 0, 0, 1, 1, 5'd31));
    wait_ready();
    wr(OFS_XFER, 32'h4000_0000);
    repeat (20) @(negedge clk);
    rd(OFS_FSTAT, d); chk("R2 busy go ignored", d, 32'h0);
    rd(OFS_RXP, d);   chk("R2 first word", d, 32'hCAFE_0001);
    run_xfer(2'd0, 2'd0, 4'h0, 1, 1, 5'd31, 8'd0);
    rd(OFS_RXP, d);   chk("R2 second word", d, 32'hCAFE_0002);

    // R9 transmit overflow
    for (int i = 0; i < 5; i++) begin
      ws[i] = 32'h10 + 32'(i) * 32'h11;
      wr(OFS_TXP, ws[i]);
    end
    rd(OFS_FSTAT, d); chk("R9 tx overflow flags", d, 32'h189);
    for (int i = 0; i < 4; i++) run_xfer(2'd0, 2'd0, 4'h0, 1, 1, 5'd7, 8'd0);
    rd(OFS_FSTAT, d); chk("R12 rx full live bit", d, 32'h186);
    // R10 underrun shifts zeros; R11 receive overflow
    run_xfer(2'd0, 2'd0, 4'h0, 1, 1, 5'd7, 8'd0);
    chk("R10 zeros shifted", cap, 32'h0);
    rd(OFS_FSTAT, d); chk("R10 R11 flags", d, 32'h1E6);
    for (int i = 0; i < 4; i++) begin
      rd(OFS_RXP, d); chk($sformatf("R9 kept word %0d", i), d, ws[i]);
    end
    rd(OFS_RXP, d);   chk("R11 empty pop zero", d, 32'h0);
    rd(OFS_FSTAT, d); chk("R11 rx underrun", d, 32'h1F5);
    wr(OFS_FSTAT, 32'h010);
    rd(OFS_FSTAT, d); chk("R12 partial W1C", d, 32'h1E5);
    wr(OFS_FSTAT, 32'h1F0);
    rd(OFS_FSTAT, d); chk("R12 full W1C", d, 32'h5);

    // R13 transmit disable and receive disable
    wr(OFS_TXP, 32'h0000_5AA5);
    run_xfer(2'd1, 2'd0, 4'h0, 1, 0, 5'd15, 8'd0);
    chk("R13 tx off zeros", cap, 32'h0);
    rd(OFS_RXP, d);   chk("R13 tx off rx zero", d, 32'h0);
    rd(OFS_FSTAT, d); chk("R13 tx fifo kept", d, 32'h1);
    run_xfer(2'd1, 2'd0, 4'h0, 0, 1, 5'd15, 8'd0);
    chk("R13 rx off still sends", cap, 32'h5AA5);
    rd(OFS_FSTAT, d); chk("R13 rx off no push", d, 32'h5);

    // R7 software chip select
    wr(OFS_CMD, mk_cmd(0, 1, 2'd0, 2'd2, 4'h0, 1, 0, 0, 0, 5'd7));
    repeat (2) @(negedge clk);
    chk("R7 sw level 0", {28'b0, cs_n}, 32'hB);
    wr(OFS_CMD, mk_cmd(0, 1, 2'd0, 2'd2, 4'h0, 1, 1, 0, 0, 5'd7));
    repeat (2) @(negedge clk);
    chk("R7 sw level 1", {28'b0, cs_n}, 32'hF);

    // R8 polarity inversion
    wr(OFS_CMD, mk_cmd(0, 1, 2'd0, 2'd1, 4'b0010, 0, 0, 0, 0, 5'd7));
    repeat (2) @(negedge clk);
    chk("R8 inverted idle", {28'b0, cs_n}, 32'hD);
    wr(OFS_TXP, 32'h0000_0081);
    run_xfer(2'd0, 2'd1, 4'b0010, 1, 1, 5'd7, 8'd0);
    chk("R8 inverted active", {28'b0, cs_seen}, 32'hF);
    rd(OFS_RXP, d); chk("R8 data", d, 32'h81);
    wr(OFS_CMD, 32'h0);
    repeat (2) @(negedge clk);
    chk("R6 all idle high", {28'b0, cs_n}, 32'hF);

    finished = 1;
    summary();
    $finish;
  end
endmodule